// File: doc/BRIEF.md
# Calibrated ADC Code Scaler

This block turns a 10-bit converter code into a signed engineering value in millivolts or milliamps. Each request carries a channel class and the raw code on a valid/ready input. The class selects one of two mappings. The first is a two-point calibration, value = (code × gain + offset) / 1000, which uses one of three stored coefficient groups. The second is a nominal straight-line mapping, value = low + span × code / 1024, with a fixed range for each class.

The coefficient groups are supplied as static inputs. A group whose gain is zero counts as uncalibrated, and the classes bound to it then fall back to their nominal range. Classes that never have a calibration always use the nominal range. An unknown class returns an error flag in place of a value.

The block is a three-stage pipeline. All three stages stall together when a finished result is waiting and the output side is not ready.

Top module: `adc_code_scaler`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid_o` is 0 and `in_ready_o` is 1 until a request is accepted.
- R2: Classes 7 (die temperature, 0..1350), 8 (second accessory, 0..2500), 9 (bus voltage, 0..20030), 10 and 11 (charge currents, 0..1500) and 12 (backup cell, 0..3200) always return low + span × code / 1024, with the division truncating.
- R3: Class 6 (battery voltage) returns 2300 + 2500 × code / 1024 when the gain of group 2 is zero.
- R4: Class 0 (charger voltage) with a nonzero gain in group 0 returns (code × gain0 + offset0) / 1000. The offset is signed and the product is kept to at least 40 bits.
- R5: Classes 1 to 5 (battery control, battery temperature, first accessory, two auxiliary inputs) share group 1 and return (code × gain1 + offset1) / 1000 when gain1 is nonzero.
- R6: Class 6 with a nonzero gain in group 2 returns (code × gain2 + offset2) / 1000.
- R7: When a group gain is zero, class 0 returns 20030 × code / 1024, and classes 1 to 5 return 1350 × code / 1024.
- R8: Classes 13 to 15 produce `out_err_o` = 1 with `out_value_o` = 0. Every other class produces `out_err_o` = 0.
- R9: With `out_ready_i` held high, a request accepted at clock edge k shows its result with `out_valid_o` = 1 after edge k+2. One request can be accepted on every cycle.
- R10: While `out_valid_o` = 1 and `out_ready_i` = 0, the output value and flag hold steady and `in_ready_o` is 0. No result is lost, and results leave in the order they were accepted.
- R11: Coefficients are sampled in the cycle a request is accepted. Changing them afterwards has no effect on that request's result.
- R12: The calibrated division truncates toward zero. For example, code 0 with gain 1 and offset −1999 returns −1, not −2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cal_gain_i | input | 3×GAIN_W | Unsigned gain for each calibration group (×1000 scale) |
| cal_offset_i | input | 3×OFS_W | Signed offset for each calibration group (×1000 scale) |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request can be accepted |
| in_class_i | input | 4 | Channel class |
| in_code_i | input | CODE_W | Raw converter code |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream accepts the result |
| out_value_o | output | OUT_W | Signed result in mV or mA |
| out_err_o | output | 1 | Unknown class |

## Verification
The assertions check four things on every cycle:
- the output holds steady while it is stalled;
- an error result carries a zero value;
- an unknown class reaching the first stage raises the error marker;
- a zero gain in the selected group blocks the calibrated path and keeps a nominal result inside its range.

The arithmetic needs the bench's scenarios. These cover the exact calibrated values and truncation toward zero for negative sums, the sharing of group 1 among five classes, the sampling of coefficients at acceptance, the three-edge latency and the ordering under random back-pressure. All of these are compared against a reference model in the bench.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int NGRP  = 3;
  localparam int NOM_W = 15;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_CHG_V   = 4'd0,
    CLS_BAT_CTL = 4'd1,
    CLS_BAT_TMP = 4'd2,
    CLS_ACC_A   = 4'd3,
    CLS_AUX_A   = 4'd4,
    CLS_AUX_B   = 4'd5,
    CLS_BAT_V   = 4'd6,
    CLS_DIE_T   = 4'd7,
    CLS_ACC_B   = 4'd8,
    CLS_BUS_V   = 4'd9,
    CLS_CHG_IA  = 4'd10,
    CLS_CHG_IB  = 4'd11,
    CLS_BKUP_V  = 4'd12
  } chan_cls_e;

  typedef struct packed {
    logic             err;
    logic             cal_ok;
    logic [1:0]       grp;
    logic [NOM_W-1:0] lo;
    logic [NOM_W-1:0] span;
  } cls_map_t;
endpackage

// File: rtl/acs_class_decode.sv
module acs_class_decode
  import acs_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  output cls_map_t         map_o
);
  always_comb begin
    map_o = '0;
    case (chan_cls_e'(cls_i))
      CLS_CHG_V: begin
        map_o.cal_ok = 1'b1; map_o.grp = 2'd0; map_o.span = NOM_W'(20030);
      end
      CLS_BAT_CTL, CLS_BAT_TMP, CLS_ACC_A, CLS_AUX_A, CLS_AUX_B: begin
        map_o.cal_ok = 1'b1; map_o.grp = 2'd1; map_o.span = NOM_W'(1350);
      end
      CLS_BAT_V: begin
        map_o.cal_ok = 1'b1; map_o.grp = 2'd2;
        map_o.lo = NOM_W'(2300); map_o.span = NOM_W'(2500);
      end
      CLS_DIE_T:               map_o.span = NOM_W'(1350);
      CLS_ACC_B:               map_o.span = NOM_W'(2500);
      CLS_BUS_V:               map_o.span = NOM_W'(20030);
      CLS_CHG_IA, CLS_CHG_IB:  map_o.span = NOM_W'(1500);
      CLS_BKUP_V:              map_o.span = NOM_W'(3200);
      default:                 map_o.err  = 1'b1;
    endcase
  end
endmodule

// File: rtl/acs_mac_stage.sv
module acs_mac_stage
  import acs_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int GAIN_W = 24,
  parameter int OFS_W  = 32,
  parameter int ACC_W  = 40,
  parameter int OUT_W  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    valid_i,
  input  logic                    err_i,
  input  logic                    use_cal_i,
  input  logic [CODE_W-1:0]       code_i,
  input  logic [GAIN_W-1:0]       gain_i,
  input  logic signed [OFS_W-1:0] offset_i,
  input  logic [NOM_W-1:0]        lo_i,
  input  logic [NOM_W-1:0]        span_i,
  output logic                    valid_o,
  output logic                    err_o,
  output logic                    use_cal_o,
  output logic signed [ACC_W-1:0] acc_o,
  output logic [OUT_W-1:0]        nom_o
);
  localparam int PROD_W = CODE_W + GAIN_W;
  localparam int SCL_W  = NOM_W + CODE_W;

  logic [PROD_W-1:0]       prod;
  logic signed [ACC_W-1:0] acc_d;
  logic [SCL_W-1:0]        scaled;
  logic [OUT_W-1:0]        nom_d;

  assign prod   = code_i * gain_i;
  assign acc_d  = $signed(ACC_W'(prod)) + ACC_W'(offset_i);
  assign scaled = span_i * code_i;
  // resolution is 2^CODE_W, so the nominal divide is a shift
  assign nom_d  = OUT_W'(lo_i) + OUT_W'(scaled >> CODE_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      err_o     <= 1'b0;
      use_cal_o <= 1'b0;
      acc_o     <= '0;
      nom_o     <= '0;
    end else if (en_i) begin
      valid_o   <= valid_i;
      err_o     <= err_i;
      use_cal_o <= use_cal_i;
      acc_o     <= acc_d;
      nom_o     <= nom_d;
    end
  end

  AST_NOM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && valid_i && !err_i && !use_cal_i |=>
      (nom_o >= OUT_W'($past(lo_i))) &&
      (nom_o <  OUT_W'($past(lo_i)) + OUT_W'($past(span_i)))); // R2
endmodule

// File: rtl/acs_out_stage.sv
module acs_out_stage #(
  parameter int ACC_W     = 40,
  parameter int OUT_W     = 32,
  parameter int CAL_SCALE = 1000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    valid_i,
  input  logic                    err_i,
  input  logic                    use_cal_i,
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [OUT_W-1:0]        nom_i,
  output logic                    valid_o,
  output logic [OUT_W-1:0]        value_o,
  output logic                    err_o
);
  localparam logic signed [ACC_W-1:0] SCALE = ACC_W'(CAL_SCALE);

  logic signed [ACC_W-1:0] quo;
  logic [OUT_W-1:0]        value_d;

  // signed division truncates toward zero
  assign quo = acc_i / SCALE;

  always_comb begin
    if (err_i)          value_d = '0;
    else if (use_cal_i) value_d = OUT_W'(quo);
    else                value_d = nom_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      value_o <= '0;
      err_o   <= 1'b0;
    end else if (en_i) begin
      valid_o <= valid_i;
      value_o <= value_d;
      err_o   <= err_i;
    end
  end

  AST_ERR_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && err_o |-> value_o == '0); // R8
endmodule

// File: rtl/adc_code_scaler.sv
module adc_code_scaler
  import acs_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int GAIN_W    = 24,
  parameter int OFS_W     = 32,
  parameter int OUT_W     = 32,
  parameter int CAL_SCALE = 1000
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NGRP-1:0][GAIN_W-1:0]      cal_gain_i,
  input  logic [NGRP-1:0][OFS_W-1:0]       cal_offset_i,
  input  logic                             in_valid_i,
  output logic                             in_ready_o,
  input  logic [CLS_W-1:0]                 in_class_i,
  input  logic [CODE_W-1:0]                in_code_i,
  output logic                             out_valid_o,
  input  logic                             out_ready_i,
  output logic [OUT_W-1:0]                 out_value_o,
  output logic                             out_err_o
);
  localparam int PROD_W = CODE_W + GAIN_W;
  localparam int RAW_W  = ((PROD_W > OFS_W) ? PROD_W : OFS_W) + 2;
  localparam int ACC_W  = (RAW_W < 40) ? 40 : RAW_W;

  logic adv;
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;

  cls_map_t          map;
  logic [GAIN_W-1:0] sel_gain;
  logic [OFS_W-1:0]  sel_ofs;
  logic              use_cal;

  acs_class_decode u_dec (.cls_i(in_class_i), .map_o(map));

  always_comb begin
    sel_gain = '0;
    sel_ofs  = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (map.grp == 2'(g)) begin
        sel_gain = cal_gain_i[g];
        sel_ofs  = cal_offset_i[g];
      end
    end
  end

  // zero gain marks an uncalibrated group
  assign use_cal = map.cal_ok && (sel_gain != '0);

  logic                    s1_vld, s1_err, s1_cal;
  logic [CODE_W-1:0]       s1_code;
  logic [GAIN_W-1:0]       s1_gain;
  logic signed [OFS_W-1:0] s1_ofs;
  logic [NOM_W-1:0]        s1_lo, s1_span;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0; s1_err <= 1'b0; s1_cal <= 1'b0;
      s1_code <= '0; s1_gain <= '0; s1_ofs <= '0;
      s1_lo <= '0; s1_span <= '0;
    end else if (adv) begin
      s1_vld  <= in_valid_i;
      s1_err  <= map.err;
      s1_cal  <= use_cal;
      s1_code <= in_code_i;
      s1_gain <= sel_gain;
      s1_ofs  <= $signed(sel_ofs);
      s1_lo   <= map.lo;
      s1_span <= map.span;
    end
  end

  logic                    s2_vld, s2_err, s2_cal;
  logic signed [ACC_W-1:0] s2_acc;
  logic [OUT_W-1:0]        s2_nom;

  acs_mac_stage #(
    .CODE_W(CODE_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W), .ACC_W(ACC_W), .OUT_W(OUT_W)
  ) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(adv),
    .valid_i(s1_vld), .err_i(s1_err), .use_cal_i(s1_cal),
    .code_i(s1_code), .gain_i(s1_gain), .offset_i(s1_ofs),
    .lo_i(s1_lo), .span_i(s1_span),
    .valid_o(s2_vld), .err_o(s2_err), .use_cal_o(s2_cal),
    .acc_o(s2_acc), .nom_o(s2_nom)
  );

  acs_out_stage #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .CAL_SCALE(CAL_SCALE)
  ) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(adv),
    .valid_i(s2_vld), .err_i(s2_err), .use_cal_i(s2_cal),
    .acc_i(s2_acc), .nom_i(s2_nom),
    .valid_o(out_valid_o), .value_o(out_value_o), .err_o(out_err_o)
  );

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=>
      out_valid_o && $stable(out_value_o) && $stable(out_err_o)); // R10

  AST_BAD_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (in_class_i > 4'd12) |=> s1_vld && s1_err); // R8

  AST_ZERO_GAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (sel_gain == '0) |=> !s1_cal); // R7
endmodule

// File: tb/tb_adc_code_scaler.sv
`timescale 1ns/1ps
module tb_adc_code_scaler;
  localparam int CODE_W = 10;
  localparam int GAIN_W = 24;
  localparam int OFS_W  = 32;
  localparam int OUT_W  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0][GAIN_W-1:0] gain = '0;
  logic [2:0][OFS_W-1:0]  ofs  = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_class = '0;
  logic [CODE_W-1:0] in_code = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [OUT_W-1:0] out_value;
  logic out_err;

  always #2.5 clk = ~clk;

  adc_code_scaler dut (
    .clk_i(clk), .rst_ni(rst_n), .cal_gain_i(gain), .cal_offset_i(ofs),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_class_i(in_class),
    .in_code_i(in_code), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_value_o(out_value), .out_err_o(out_err)
  );

  typedef struct { int val; bit err; string req; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit acc_flag = 1'b0, done = 1'b0;
  string tag_ovr = "";

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(input int cls, input int code);
    exp_t e;
    int g;
    longint lo, sp, s;
    e.err = 1'b0; e.val = 0; g = -1; lo = 0; sp = 0;
    case (cls)
      0: begin g = 0; sp = 20030; e.req = "R4"; end
      1, 2, 3, 4, 5: begin g = 1; sp = 1350; e.req = "R5"; end
      6: begin g = 2; lo = 2300; sp = 2500; e.req = "R6"; end
      7: sp = 1350;
      8: sp = 2500;
      9: sp = 20030;
      10, 11: sp = 1500;
      12: sp = 3200;
      default: begin e.err = 1'b1; e.req = "R8"; return e; end
    endcase
    if (g < 0) e.req = "R2";
    if (g >= 0 && gain[g] != 0) begin
      s = longint'(code) * longint'(gain[g]) + longint'($signed(ofs[g]));
      e.val = int'(s / 1000);
    end else begin
      if (g == 2) e.req = "R3";
      else if (g >= 0) e.req = "R7";
      e.val = int'(lo + (sp * code) / 1024);
    end
    return e;
  endfunction

  // monitor: handshake values are settled 1 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk); #1;
      acc_flag = in_valid && in_ready;
      if (rst_n) begin
        if (acc_flag) begin
          exp_t e;
          e = model(int'(in_class), int'(in_code));
          if (tag_ovr != "") e.req = tag_ovr;
          q.push_back(e);
        end
        if (out_valid && out_ready) begin
          if (q.size() == 0) chk("R10", 1'b0, 1, 0);
          else begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, out_err == e.err, longint'(out_err), longint'(e.err));
            chk(e.req, $signed(out_value) == e.val, longint'($signed(out_value)), longint'(e.val));
          end
        end
      end
    end
  end

  task automatic send(input int cls, input int code);
    @(negedge clk);
    in_valid = 1'b1; in_class = 4'(cls); in_code = CODE_W'(code);
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL R9: watchdog expired, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk("R1", out_valid == 1'b0, out_valid, 0);
    chk("R1", in_ready == 1'b1, in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", out_valid == 1'b0, out_valid, 0);
    chk("R1", in_ready == 1'b1, in_ready, 1);

    // R9 latency: accept edge k, valid after k+2
    @(negedge clk);
    in_valid = 1'b1; in_class = 4'd7; in_code = 10'd1023;
    @(negedge clk); in_valid = 1'b0; #2;
    chk("R9", out_valid == 1'b0, out_valid, 0);
    @(negedge clk); #2;
    chk("R9", out_valid == 1'b0, out_valid, 0);
    @(negedge clk); #2;
    chk("R9", out_valid == 1'b1, out_valid, 1);
    drain();

    // nominal ranges, all gains zero (R2, R3, R7)
    for (int c = 0; c < 13; c++) begin
      send(c, 0);
      send(c, 1023);
      send(c, 517);
    end
    drain();

    // calibrated groups (R4, R5, R6)
    gain[0] = 24'd19556; ofs[0] = 32'(2668);
    gain[1] = 24'd1300;  ofs[1] = 32'(-20000);
    gain[2] = 24'd2440;  ofs[2] = 32'(2300000);
    for (int c = 0; c < 7; c++) begin
      send(c, 0);
      send(c, 500);
      send(c, 1023);
    end
    drain();

    // R12 truncation toward zero
    tag_ovr = "R12";
    gain[0] = 24'd1; ofs[0] = 32'(-1999);
    send(0, 0);
    gain[1] = 24'd3; ofs[1] = 32'(-3001);
    send(2, 1);
    tag_ovr = "";
    drain();

    // R8 unknown classes
    for (int c = 13; c < 16; c++) send(c, 300);
    drain();

    // R11 coefficients sampled at acceptance
    tag_ovr = "R11";
    gain[2] = 24'd2440; ofs[2] = 32'(2300000);
    send(6, 800);
    tag_ovr = "";
    gain[2] = 24'd9; ofs[2] = 32'(-77);
    drain();

    // R10 back-pressure: three accepted, then stall
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_class = 4'd9; in_code = 10'd321;
    repeat (5) @(negedge clk);
    #2;
    chk("R10", in_ready == 1'b0, in_ready, 0);
    chk("R10", out_valid == 1'b1, out_valid, 1);
    begin
      logic [OUT_W-1:0] held;
      held = out_value;
      repeat (3) @(negedge clk);
      #2;
      chk("R10", out_value == held, out_value, held);
    end
    drain();

    // random traffic with random back-pressure and coefficients
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (c % 200 == 0) begin
        for (int g = 0; g < 3; g++) begin
          gain[g] = ($urandom % 4 == 0) ? '0 : GAIN_W'($urandom % 30000);
          ofs[g]  = OFS_W'(int'($urandom % 6000000) - 3000000);
        end
      end
      out_ready = ($urandom % 10) < 7;
      if (!in_valid || acc_flag) begin
        in_valid = ($urandom % 10) < 7;
        in_class = 4'($urandom % 16);
        in_code  = CODE_W'($urandom % 1024);
      end
    end
    drain();
    chk("R10", q.size() == 0, q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule